// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This unit keeps a 64-bit compare value for the supervisor timer and produces the supervisor timer-pending bit by comparing that value, unsigned, against the free-running machine time. It sits beside the main CSR file. It claims a small set of CSR addresses: the compare value (one address on a 64-bit hart, two 32-bit halves on a 32-bit hart), the word of the machine environment configuration that holds the timer-compare enable bit, and the machine interrupt-pending register, of which it owns only the supervisor-timer bit.

On each access the unit decides whether the address is defined and whether the current privilege may touch it. A refused access raises a fault flag, returns zero and changes nothing. Read data is combinational. For a write, the read data is the value the target holds after the write. While the enable bit is set, the compare result owns the pending bit and software writes to that bit are dropped. While it is clear, the pending bit is an ordinary software-writable flag.

A synthesis parameter can remove the extension. The compare addresses then fault, the enable bit reads zero, and the pending bit is purely software-driven.

Top module: `stc_timer_unit`

## Requirements
- R1: After reset, the compare value is all ones, the enable bit is 0 and the pending output is 0.
- R2: With XLEN=32, address 0x14D holds compare bits 31..0 and 0x15D holds bits 63..32. A write changes only the addressed half. For a write, the read data equals the new half; for a read, it equals the stored half.
- R3: Machine privilege (2'b11) may always access the compare addresses. Supervisor privilege (2'b01) may access them only when tm_en is 1 and the enable bit is 1. User privilege (2'b00) never may. A refused access drives csr_fault to 1 and csr_rdata to 0, and leaves all state unchanged.
- R4: When the extension or supervisor mode is absent, 0x14D and 0x15D fault for every privilege. With XLEN=64, 0x15D always faults.
- R5: While the enable bit is 1 and the extension is present, sti_pend equals the unsigned test compare <= mtime, taken over the values of the previous cycle.
- R6: Address 0x344 is machine-only, and its bit 5 is the pending bit. A write there is ignored while the enable bit is 1 with the extension present; otherwise it sets or clears the pending bit.
- R7: The enable bit sits at bit 31 of address 0x31A (XLEN=32) or at bit 63 of address 0x30A (XLEN=64). It is machine-only. A write of 1 takes effect only when the extension is present; otherwise the bit reads 0.
- R8: Rewriting the compare value to a time beyond mtime drops sti_pend at the second clock edge after the write is presented.
- R9: An access to any address the unit does not claim returns zero read data and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_req | input | 1 | A CSR access is presented this cycle |
| csr_we | input | 1 | The access is a write |
| csr_priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| tm_en | input | 1 | Timer bit of the machine counter-enable register |
| mtime | input | 64 | Machine time value |
| csr_rdata | output | XLEN | Read data, or the value after the write for a write |
| csr_fault | output | 1 | Access is undefined or not permitted |
| sti_pend | output | 1 | Supervisor timer interrupt pending |

## Verification
The bench targets these corner cases:
- A compare equal to mtime must assert the pending bit, and a design using strict less-than would miss that cycle.
- A compare whose upper half has its top bit set must stay above mtime, and a signed comparator would raise a false interrupt there.
- A half write that also disturbs the other half shows up when the untouched half is read back.
- Supervisor access is tried with each of the two gate bits missing, and pending-bit writes are tried while the compare owns the bit. Either leak would show as a wrong fault flag or a pending bit that flips.
- A second instance without the extension confirms that the compare addresses fault there and that the enable bit cannot be set.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  localparam logic [11:0] ADDR_CMP_LO = 12'h14D;
  localparam logic [11:0] ADDR_CMP_HI = 12'h15D;
  localparam logic [11:0] ADDR_ENV_LO = 12'h30A;
  localparam logic [11:0] ADDR_ENV_HI = 12'h31A;
  localparam logic [11:0] ADDR_PEND   = 12'h344;

  localparam int CMP_W   = 64;
  localparam int STI_BIT = 5;

  typedef struct packed {
    logic cmp_lo;
    logic cmp_hi;
    logic env;
    logic pend;
  } sel_t;
endpackage

// File: rtl/stc_decode.sv
module stc_decode
  import stc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_STC   = 1'b1
) (
  input  logic        req,
  input  logic        we,
  input  logic [1:0]  priv,
  input  logic [11:0] addr,
  input  logic        tm_en,
  input  logic        stce,
  output sel_t        acc,
  output sel_t        wr,
  output logic        fault
);
  localparam logic [11:0] ENV_ADDR   = (XLEN == 32) ? ADDR_ENV_HI : ADDR_ENV_LO;
  localparam bit          CMP_DEF    = HAS_SMODE && HAS_STC;
  localparam bit          CMP_HI_DEF = CMP_DEF && (XLEN == 32);

  sel_t hit;
  logic is_m, s_gate, cmp_perm, claimed;

  always_comb begin
    hit.cmp_lo = (addr == ADDR_CMP_LO);
    hit.cmp_hi = (addr == ADDR_CMP_HI);
    hit.env    = (addr == ENV_ADDR);
    hit.pend   = (addr == ADDR_PEND);
    claimed    = |hit;

    is_m     = (priv == PRIV_M);
    s_gate   = (priv == PRIV_S) && tm_en && stce;
    cmp_perm = is_m || s_gate;

    acc.cmp_lo = req && hit.cmp_lo && CMP_DEF && cmp_perm;
    acc.cmp_hi = req && hit.cmp_hi && CMP_HI_DEF && cmp_perm;
    acc.env    = req && hit.env && is_m;
    acc.pend   = req && hit.pend && is_m;

    wr    = we ? acc : '0;
    fault = req && claimed && !(|acc);
  end
endmodule

// File: rtl/stc_cmp_reg.sv
module stc_cmp_reg
  import stc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [XLEN-1:0]  wdata,
  output logic [CMP_W-1:0] cmp
);
  logic [CMP_W-1:0] cmp_d;
  logic             cmp_en;

  generate
    if (XLEN == 32) begin : g_split
      always_comb begin
        cmp_en = we_lo || we_hi;
        cmp_d  = cmp;
        if (we_lo) cmp_d[31:0]  = wdata;
        if (we_hi) cmp_d[63:32] = wdata;
      end

      a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we_hi) && !$past(we_lo) |-> cmp[31:0] == $past(cmp[31:0]));
      a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we_lo) && !$past(we_hi) |-> cmp[63:32] == $past(cmp[63:32]));
    end else begin : g_full
      always_comb begin
        cmp_en = we_lo;
        cmp_d  = CMP_W'(wdata);
      end

      a_r4_no_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_hi);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp <= '1;
    else if (cmp_en) cmp <= cmp_d;
  end
endmodule

// File: rtl/stc_irq.sv
module stc_irq
  import stc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit HAS_STC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             env_we,
  input  logic             pend_we,
  input  logic [XLEN-1:0]  wdata,
  input  logic [CMP_W-1:0] cmp,
  input  logic [63:0]      mtime,
  output logic             stce,
  output logic             lock,
  output logic             sti
);
  logic stce_d, sti_d, stce_en, due;

  always_comb begin
    lock    = HAS_STC && stce;
    due     = (cmp <= mtime);
    stce_en = env_we;
    stce_d  = HAS_STC && wdata[XLEN-1];
    if (lock)         sti_d = due;
    else if (pend_we) sti_d = wdata[STI_BIT];
    else              sti_d = sti;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stce <= 1'b0;
      sti  <= 1'b0;
    end else begin
      if (stce_en) stce <= stce_d;
      sti <= sti_d;
    end
  end

  a_r7_env_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $past(env_we) && !HAS_STC |-> !stce);
  a_r6_sw_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend_we) && !$past(lock) |-> sti == $past(wdata[STI_BIT]));
endmodule

// File: rtl/stc_timer_unit.sv
module stc_timer_unit
  import stc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_STC   = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_req,
  input  logic            csr_we,
  input  logic [1:0]      csr_priv,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            tm_en,
  input  logic [63:0]     mtime,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_fault,
  output logic            sti_pend
);
  logic             rs_q1, rs_q2, srst_n;
  sel_t             acc, wr;
  logic [CMP_W-1:0] cmp;
  logic             stce, lock, sti;
  logic [XLEN-1:0]  cmp_lo_view, cmp_hi_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign srst_n = rs_q2;

  stc_decode #(.XLEN(XLEN), .HAS_SMODE(HAS_SMODE), .HAS_STC(HAS_STC)) u_decode (
    .req(csr_req), .we(csr_we), .priv(csr_priv), .addr(csr_addr),
    .tm_en(tm_en), .stce(stce), .acc(acc), .wr(wr), .fault(csr_fault)
  );

  stc_cmp_reg #(.XLEN(XLEN)) u_cmp (
    .clk(clk), .rst_n(srst_n), .we_lo(wr.cmp_lo), .we_hi(wr.cmp_hi),
    .wdata(csr_wdata), .cmp(cmp)
  );

  stc_irq #(.XLEN(XLEN), .HAS_STC(HAS_STC)) u_irq (
    .clk(clk), .rst_n(srst_n), .env_we(wr.env), .pend_we(wr.pend),
    .wdata(csr_wdata), .cmp(cmp), .mtime(mtime),
    .stce(stce), .lock(lock), .sti(sti)
  );

  assign sti_pend    = sti;
  assign cmp_lo_view = cmp[XLEN-1:0];
  assign cmp_hi_view = XLEN'(cmp[CMP_W-1:32]);

  always_comb begin
    csr_rdata = '0;
    if (acc.cmp_lo) csr_rdata = csr_we ? csr_wdata : cmp_lo_view;
    if (acc.cmp_hi) csr_rdata = csr_we ? csr_wdata : cmp_hi_view;
    if (acc.env)
      csr_rdata[XLEN-1] = csr_we ? (HAS_STC && csr_wdata[XLEN-1]) : stce;
    if (acc.pend)
      csr_rdata[STI_BIT] = (csr_we && !lock) ? csr_wdata[STI_BIT] : sti;
  end

  a_r3_fault_freezes_cmp: assert property (@(posedge clk) disable iff (!srst_n)
    csr_fault |=> $stable(cmp));
  a_r3_user_no_write: assert property (@(posedge clk) disable iff (!srst_n)
    csr_req && csr_we && csr_priv == PRIV_U |=> $stable(cmp) && $stable(stce));
  a_r3_fault_reads_zero: assert property (@(posedge clk) disable iff (!srst_n)
    csr_fault |-> csr_rdata == '0);
  a_r5_compare_owns_sti: assert property (@(posedge clk) disable iff (!srst_n)
    $past(lock) |-> sti_pend == ($past(cmp) <= $past(mtime)));
  a_r6_locked_write_dropped: assert property (@(posedge clk) disable iff (!srst_n)
    lock && wr.pend |=> sti_pend == $past(cmp <= mtime));
endmodule

// File: tb/stc_timer_unit_tb.sv
`timescale 1ns/1ps
module stc_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we, tm;
  logic [1:0]  pv;
  logic [11:0] ad;
  logic [31:0] wd;
  logic [63:0] mt;
  logic [31:0] rd0, rd1;
  logic        f0, f1, s0, s1;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  logic [63:0] mc [2];
  logic        ms [2];
  logic        mi [2];

  always #2.5 clk = ~clk;

  stc_timer_unit #(.XLEN(32), .HAS_SMODE(1'b1), .HAS_STC(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_req(req), .csr_we(we), .csr_priv(pv),
    .csr_addr(ad), .csr_wdata(wd), .tm_en(tm), .mtime(mt),
    .csr_rdata(rd0), .csr_fault(f0), .sti_pend(s0)
  );

  stc_timer_unit #(.XLEN(32), .HAS_SMODE(1'b1), .HAS_STC(1'b0)) u_dut_noext (
    .clk(clk), .rst_n(rst_n), .csr_req(req), .csr_we(we), .csr_priv(pv),
    .csr_addr(ad), .csr_wdata(wd), .tm_en(tm), .mtime(mt),
    .csr_rdata(rd1), .csr_fault(f1), .sti_pend(s1)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit r, bit w, logic [1:0] p, logic [11:0] a,
                      logic [31:0] d, bit t, logic [63:0] m);
    logic [63:0] nc [2];
    logic        ns [2];
    logic        ni [2];
    req = r; we = w; pv = p; ad = a; wd = d; tm = t; mt = m;
    #1;
    for (int i = 0; i < 2; i++) begin
      bit ext = (i == 0);
      bit lo = (a == 12'h14D), hi = (a == 12'h15D);
      bit cf = (a == 12'h31A), pe = (a == 12'h344);
      bit mm = (p == 2'b11);
      bit cmp_ok = ext && (mm || (p == 2'b01 && t && ms[i]));
      bit ok = r && ((lo || hi) ? cmp_ok : ((cf || pe) ? mm : 1'b0));
      bit locked = ext && ms[i];
      bit flt = r && (lo || hi || cf || pe) && !ok;
      logic [31:0] erd = 32'h0;
      nc[i] = mc[i]; ns[i] = ms[i]; ni[i] = mi[i];
      if (ok) begin
        if (lo) erd = w ? d : mc[i][31:0];
        if (hi) erd = w ? d : mc[i][63:32];
        if (cf) erd = (w ? (ext & d[31]) : ms[i]) ? 32'h8000_0000 : 32'h0;
        if (pe) erd = ((w && !locked) ? d[5] : mi[i]) ? 32'h20 : 32'h0;
        if (w && lo) nc[i][31:0]  = d;
        if (w && hi) nc[i][63:32] = d;
        if (w && cf) ns[i] = ext & d[31];
        if (w && pe && !locked) ni[i] = d[5];
      end
      if (locked) ni[i] = (mc[i] <= m);
      if (i == 0) begin
        chk({tag, " rdata"}, rd0, erd);
        chk({tag, " fault"}, f0, flt);
        chk({tag, " sti"}, s0, mi[i]);
      end else begin
        chk({tag, " noext rdata"}, rd1, erd);
        chk({tag, " noext fault"}, f1, flt);
        chk({tag, " noext sti"}, s1, mi[i]);
      end
    end
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      mc[i] = nc[i]; ms[i] = ns[i]; mi[i] = ni[i];
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      mc[i] = '1; ms[i] = 1'b0; mi[i] = 1'b0;
    end
    rst_n = 1'b0;
    req = 0; we = 0; pv = 2'b11; ad = 12'h0; wd = 0; tm = 0; mt = 64'd100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state visible through reads
    step("R1 idle", 0, 0, 2'b11, 12'h000, 0, 0, 64'd100);
    step("R1 lo",   1, 0, 2'b11, 12'h14D, 0, 0, 64'd100);
    step("R1 hi",   1, 0, 2'b11, 12'h15D, 0, 0, 64'd100);
    step("R1 env",  1, 0, 2'b11, 12'h31A, 0, 0, 64'd100);
    // R3: supervisor gated while enable bit is clear
    step("R3 s-no-stce", 1, 0, 2'b01, 12'h14D, 0, 1, 64'd100);
    // R7: set enable bit (extension instance only)
    step("R7 set", 1, 1, 2'b11, 12'h31A, 32'h8000_0000, 1, 64'd100);
    step("R7 read", 1, 0, 2'b11, 12'h31A, 0, 1, 64'd100);
    // R2: half writes; R4 on the instance without the extension
    step("R2 lo", 1, 1, 2'b11, 12'h14D, 32'd50, 1, 64'd100);
    step("R2 hi-rd", 1, 0, 2'b11, 12'h15D, 0, 1, 64'd100);
    step("R2 hi", 1, 1, 2'b11, 12'h15D, 32'd0, 1, 64'd100);
    step("R5 rise", 0, 0, 2'b11, 12'h000, 0, 1, 64'd100);
    step("R5 held", 1, 0, 2'b11, 12'h14D, 0, 1, 64'd100);
    // R6: pending writes refused for supervisor, ignored while locked
    step("R6 s-write", 1, 1, 2'b01, 12'h344, 32'h0, 1, 64'd100);
    step("R6 m-clear", 1, 1, 2'b11, 12'h344, 32'h0, 1, 64'd100);
    step("R6 after", 1, 0, 2'b11, 12'h344, 0, 1, 64'd100);
    // R3: supervisor without tm_en faults, with both gates passes
    step("R3 s-no-tm", 1, 1, 2'b01, 12'h14D, 32'd1, 0, 64'd100);
    step("R8 s-future", 1, 1, 2'b01, 12'h14D, 32'd200, 1, 64'd100);
    step("R8 edge1", 0, 0, 2'b11, 12'h000, 0, 1, 64'd100);
    step("R8 edge2", 0, 0, 2'b11, 12'h000, 0, 1, 64'd100);
    // R5: equality asserts
    step("R5 equal", 0, 0, 2'b11, 12'h000, 0, 1, 64'd200);
    step("R5 equal2", 0, 0, 2'b11, 12'h000, 0, 1, 64'd200);
    // R5: unsigned compare with top bit set
    step("R5 unsigned", 1, 1, 2'b11, 12'h15D, 32'h8000_0000, 1, 64'hFFFF_FFFF_0000_0000);
    step("R5 unsigned2", 0, 0, 2'b11, 12'h000, 0, 1, 64'hFFFF_FFFF_0000_0000);
    step("R5 unsigned3", 0, 0, 2'b11, 12'h000, 0, 1, 64'h0000_0000_FFFF_0000);
    // R3: user privilege
    step("R3 user-rd", 1, 0, 2'b00, 12'h14D, 0, 1, 64'd0);
    step("R3 user-wr", 1, 1, 2'b00, 12'h31A, 0, 1, 64'd0);
    // R9: foreign address
    step("R9 foreign", 1, 1, 2'b11, 12'h123, 32'hFFFF_FFFF, 1, 64'd0);
    step("R9 env-lo", 1, 0, 2'b11, 12'h30A, 0, 1, 64'd0);
    // R6: unlocked writes take effect
    step("R7 clear", 1, 1, 2'b11, 12'h31A, 32'h0, 1, 64'd0);
    step("R6 set", 1, 1, 2'b11, 12'h344, 32'h20, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R6 clr", 1, 1, 2'b11, 12'h344, 32'h0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R6 idle", 0, 0, 2'b11, 12'h000, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);

    // Mixed traffic against the reference model
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [1:0]  p;
      logic [31:0] d;
      logic [63:0] m;
      case ($urandom % 6)
        0: a = 12'h14D;
        1: a = 12'h15D;
        2: a = 12'h31A;
        3: a = 12'h344;
        4: a = 12'h30A;
        default: a = 12'h2A0;
      endcase
      case ($urandom % 3)
        0: p = 2'b00;
        1: p = 2'b01;
        default: p = 2'b11;
      endcase
      d = $urandom;
      if (a == 12'h15D) d = $urandom % 2;
      if (a == 12'h14D) d = $urandom % 1024;
      m = {31'd0, 1'($urandom % 2), 22'd0, 10'($urandom % 1024)};
      step("R5 mix", 1'($urandom % 2), 1'($urandom % 2), p, a, d, 1'($urandom % 2), m);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end
endmodule